// File: doc/BRIEF.md
# Keyboard Port Interrupt Merger

This block collects interrupt requests from eight general-purpose port pins and one dedicated interrupt pin into a single shared request latch. All sources are active-low. Each port pin takes part only when its bit in an 8-bit enable register is set. The dedicated pin can be kept out of the latch by a disable bit. The latched request reaches the CPU through one request line, which a mask bit can block.

Software configures the block through two byte-wide registers on a small register bus. The control/status register holds these fields:
- a trigger mode: falling edge only, or falling edge or low level;
- the mask;
- a write-only acknowledge;
- the dedicated-pin disable;
- a read-only image of the dedicated pin's level. Software reads this image to tell a dedicated-pin request from a port-pin request.

When the CPU services the interrupt, it pulses an acknowledge input, and this also clears the latch. Each enable bit drives a pull-up enable and an input-direction override for its port pin.

Top module: `kbd_irq_merge`

## Requirements
- R1: After reset, the enable register, the mode, mask and disable bits, `irq_req`, `pull_en` and `dir_in_force` are all 0.
- R2: At `reg_addr`=1, a write stores `reg_wdata` into the enable register and a read returns it. `pull_en` and `dir_in_force` equal the enable register, bit for bit.
- R3: A port pin whose enable bit is 0 never sets the latch, whatever its level.
- R4: The port pins whose enable bits are 1 are combined as an active-low AND. A falling edge of the combined signal sets the latch, and `irq_req` rises within 4 clock cycles of the pin change.
- R5: A falling edge on `xpin_n` sets the latch. When control bit 3 (disable) is 1, `xpin_n` cannot set the latch, but enabled port pins still can.
- R6: Control bit 0 selects the trigger mode. With 0 (edge only), a source held low does not set the latch again after it is cleared. With 1 (edge or level), the latch sets again on the cycle after a clear while any source is low.
- R7: Control bit 1 (mask) forces `irq_req` to 0. A request latched while masked appears on `irq_req` once the mask is cleared.
- R8: Writing 1 to control bit 2 (acknowledge) clears the latch. That bit always reads 0.
- R9: A one-cycle pulse on `irq_ack` clears the latch.
- R10: Control bit 4 reads the synchronized level of `xpin_n`.
- R11: At `reg_addr`=0, a read returns {3'b000, level, disable, 1'b0, mask, mode}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kpin_n | input | 8 | Port pins, active-low, asynchronous |
| xpin_n | input | 1 | Dedicated interrupt pin, active-low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = enable register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| irq_ack | input | 1 | CPU service acknowledge, clears the latch |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| pull_en | output | 8 | Per-pin pull-up enable |
| dir_in_force | output | 8 | Per-pin input-direction override |

## Verification
The shared latch is hidden state, so a latch stuck set or stuck clear shows as `irq_req` being wrong about four cycles after a pin change. It also shows one or two cycles after an acknowledge or a mask change. A wrong mode or disable decision shows only when a source is held low across a clear, or when the dedicated pin falls while disabled. The bench therefore checks `irq_req` in the settled window after each stimulus. It also reads the registers back to expose the stored fields and the pin image.

// File: rtl/kim_pkg.sv
package kim_pkg;
  localparam int DATA_W   = 8;
  localparam bit ADR_CTRL = 1'b0;
  localparam bit ADR_EN   = 1'b1;
  localparam int CB_MODE  = 0;
  localparam int CB_MASK  = 1;
  localparam int CB_ACK   = 2;
  localparam int CB_DIS   = 3;
  localparam int CB_LVL   = 4;
endpackage

// File: rtl/kim_sync.sv
module kim_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/kim_merge.sv
module kim_merge #(
  parameter int NKEY = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NKEY-1:0] key_s,
  input  logic [NKEY-1:0] key_en,
  input  logic            xpin_s,
  input  logic            xpin_dis,
  output logic            grp_n
);
  logic [NKEY-1:0] gated;

  for (genvar g = 0; g < NKEY; g++) begin : g_gate
    assign gated[g] = key_s[g] | ~key_en[g];
  end

  assign grp_n = (&gated) & (xpin_s | xpin_dis);

  AST_DIS_BLOCKS_XPIN: assert property (@(posedge clk) disable iff (rst)
    (xpin_dis && !xpin_s && ((key_s | ~key_en) == '1)) |-> grp_n); // R5
endmodule

// File: rtl/kim_latch.sv
module kim_latch (
  input  logic clk,
  input  logic rst,
  input  logic grp_n,
  input  logic lvl_mode,
  input  logic clr,
  output logic lat_q
);
  logic grp_d;
  logic fall;
  logic set;

  assign fall = grp_d & ~grp_n;
  assign set  = fall | (lvl_mode & ~grp_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_d <= 1'b1;
      lat_q <= 1'b0;
    end else begin
      grp_d <= grp_n;
      if (clr)      lat_q <= 1'b0;
      else if (set) lat_q <= 1'b1;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lat_q); // R8
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (fall && !clr) |=> lat_q); // R4
  AST_EDGE_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && !fall && !lat_q) |=> !lat_q); // R6
endmodule

// File: rtl/kim_regs.sv
module kim_regs
  import kim_pkg::*;
#(
  parameter int NKEY = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xpin_lvl,
  output logic [DATA_W-1:0] rdata,
  output logic [NKEY-1:0]   key_en,
  output logic              lvl_mode,
  output logic              mask,
  output logic              xpin_dis,
  output logic              ack_wr
);
  logic [DATA_W-1:0] ctrl_img;
  logic [DATA_W-1:0] en_img;

  assign ack_wr = we && (addr == ADR_CTRL) && wdata[CB_ACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_en   <= '0;
      lvl_mode <= 1'b0;
      mask     <= 1'b0;
      xpin_dis <= 1'b0;
    end else if (we) begin
      if (addr == ADR_EN) key_en <= wdata[NKEY-1:0];
      else begin
        lvl_mode <= wdata[CB_MODE];
        mask     <= wdata[CB_MASK];
        xpin_dis <= wdata[CB_DIS];
      end
    end
  end

  always_comb begin
    ctrl_img          = '0;
    ctrl_img[CB_MODE] = lvl_mode;
    ctrl_img[CB_MASK] = mask;
    ctrl_img[CB_DIS]  = xpin_dis;
    ctrl_img[CB_LVL]  = xpin_lvl;
    en_img            = '0;
    en_img[NKEY-1:0]  = key_en;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (addr == ADR_EN) ? en_img : ctrl_img;
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADR_EN) |=> key_en == $past(wdata[NKEY-1:0])); // R2
  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADR_CTRL) |=> !rdata[CB_ACK]); // R8
endmodule

// File: rtl/kbd_irq_merge.sv
module kbd_irq_merge
  import kim_pkg::*;
#(
  parameter int NKEY   = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NKEY-1:0]   kpin_n,
  input  logic              xpin_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [NKEY-1:0]   pull_en,
  output logic [NKEY-1:0]   dir_in_force
);
  localparam int SW = NKEY + 1;

  logic [SW-1:0]   sync_q;
  logic [NKEY-1:0] key_s;
  logic            xpin_s;
  logic [NKEY-1:0] key_en;
  logic            lvl_mode, mask, xpin_dis, ack_wr;
  logic            grp_n, lat_q;

  kim_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({xpin_n, kpin_n}), .q(sync_q)
  );
  assign key_s  = sync_q[NKEY-1:0];
  assign xpin_s = sync_q[NKEY];

  kim_regs #(.NKEY(NKEY)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .xpin_lvl(xpin_s), .rdata(reg_rdata), .key_en(key_en),
    .lvl_mode(lvl_mode), .mask(mask), .xpin_dis(xpin_dis), .ack_wr(ack_wr)
  );

  kim_merge #(.NKEY(NKEY)) u_merge (
    .clk(clk), .rst(rst), .key_s(key_s), .key_en(key_en),
    .xpin_s(xpin_s), .xpin_dis(xpin_dis), .grp_n(grp_n)
  );

  kim_latch u_latch (
    .clk(clk), .rst(rst), .grp_n(grp_n), .lvl_mode(lvl_mode),
    .clr(ack_wr | irq_ack), .lat_q(lat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= lat_q & ~mask;
  end

  assign pull_en      = key_en;
  assign dir_in_force = key_en;

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq_req); // R7
  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> ##1 !irq_req); // R9
endmodule

// File: tb/kbd_irq_merge_tb.sv
module kbd_irq_merge_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] kpin_n = 8'hFF;
  logic       xpin_n = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic [7:0] pull_en, dir_in_force;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  kbd_irq_merge u_dut (
    .clk(clk), .rst(rst), .kpin_n(kpin_n), .xpin_n(xpin_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .pull_en(pull_en), .dir_in_force(dir_in_force)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push(input string tag, input int kind, input logic [7:0] e);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic exp_irq(input string tag, input logic e);
    tick(6);
    push(tag, 0, {7'd0, e});
  endtask

  task automatic exp_rd(input string tag, input logic a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    tick(2);
    push(tag, 1, e);
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      wait (sb.size() > 0);
      it = sb.pop_front();
      case (it.kind)
        0:       act = {7'd0, irq_req};
        1:       act = reg_rdata;
        2:       act = pull_en;
        default: act = dir_in_force;
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    tick(3);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    exp_irq("R1 irq_req", 1'b0);
    exp_rd("R1 ctrl", 1'b0, 8'h10);
    exp_rd("R1 enable", 1'b1, 8'h00);
    push("R1 pull_en", 2, 8'h00);
    push("R1 dir_in_force", 3, 8'h00);
    // R2: enable register and pin outputs
    wr(1'b1, 8'hA5);
    exp_rd("R2 enable readback", 1'b1, 8'hA5);
    push("R2 pull_en", 2, 8'hA5);
    push("R2 dir_in_force", 3, 8'hA5);
    // R3: disabled pin 1 ignored
    kpin_n[1] = 1'b0;
    exp_irq("R3 disabled pin", 1'b0);
    kpin_n[1] = 1'b1;
    // R4: enabled pin 0 falling edge
    kpin_n[0] = 1'b0;
    exp_irq("R4 enabled pin", 1'b1);
    kpin_n[0] = 1'b1;
    // R9: service acknowledge
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    exp_irq("R9 service clear", 1'b0);
    // R6 edge mode, R8 acknowledge bit
    kpin_n[2] = 1'b0;
    exp_irq("R6 edge set", 1'b1);
    wr(1'b0, 8'h04);
    exp_irq("R8 ack clears", 1'b0);
    tick(10);
    exp_irq("R6 edge no re-set while low", 1'b0);
    exp_rd("R8 ack reads zero", 1'b0, 8'h10);
    kpin_n[2] = 1'b1;
    // R6 level mode
    wr(1'b0, 8'h01);
    exp_irq("R6 level idle", 1'b0);
    kpin_n[5] = 1'b0;
    exp_irq("R6 level set", 1'b1);
    wr(1'b0, 8'h05);
    exp_irq("R6 level re-asserts", 1'b1);
    kpin_n[5] = 1'b1;
    wr(1'b0, 8'h05);
    exp_irq("R6 level released", 1'b0);
    // R5 / R10: dedicated pin
    wr(1'b0, 8'h00);
    xpin_n = 1'b0;
    exp_irq("R5 xpin sets", 1'b1);
    exp_rd("R10 level low", 1'b0, 8'h00);
    xpin_n = 1'b1;
    wr(1'b0, 8'h04);
    exp_irq("R5 cleared", 1'b0);
    wr(1'b0, 8'h08);
    xpin_n = 1'b0;
    exp_irq("R5 disabled xpin", 1'b0);
    exp_rd("R10 level with disable", 1'b0, 8'h08);
    kpin_n[7] = 1'b0;
    exp_irq("R5 key still sets", 1'b1);
    kpin_n[7] = 1'b1;
    xpin_n = 1'b1;
    wr(1'b0, 8'h04);
    exp_irq("R5 final clear", 1'b0);
    // R7: mask
    wr(1'b0, 8'h02);
    exp_rd("R11 ctrl with mask", 1'b0, 8'h12);
    kpin_n[0] = 1'b0;
    exp_irq("R7 masked", 1'b0);
    kpin_n[0] = 1'b1;
    wr(1'b0, 8'h00);
    exp_irq("R7 unmask reveals", 1'b1);
    wr(1'b0, 8'h04);
    exp_irq("R7 cleared", 1'b0);
    // R11: full layout
    wr(1'b0, 8'hFF);
    exp_rd("R11 layout", 1'b0, 8'h1B);
    wr(1'b0, 8'h04);
    exp_irq("R11 idle after restore", 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule